// File: doc/BRIEF.md
# Compare, Condition and Loop Evaluator

This block is the flag and decision unit of an integer pipeline. It compares two operands, either as full 32-bit words or as their low 16-bit halves, by subtracting the second from the first. The difference is thrown away. Only the carry, zero, sign, overflow and parity flags it yields are kept in a flag register. A 4-bit condition code is tested against those flags. The result is given both as a one-bit taken/true signal and as a set-byte value of all ones or all zeros.

The same unit carries out the three carry-control operations. It also runs the counted-loop operation: this decrements a counter and decides whether to branch, using the new count and, for two of the variants, the held zero flag.

Every operation is presented for one cycle with `valid_i` high. Its results appear on the registered outputs after the next rising clock edge. A compare tests its condition code against the flags it has just produced. Every other condition test reads the flags that are already held. Branch targets and segment handling belong to other blocks.

Top module: `cmp_cond_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all flags, `taken_o`, `setb_o` and `count_o` become zero.
- R2: Operation code 0 (compare) loads the flags from the difference a minus b, masked to the active width. The flags are set as follows:
  - CF is 1 when a is below b unsigned.
  - ZF is 1 when the difference is zero.
  - SF is the top bit of the difference.
  - OF is 1 when the operand signs differ and the result sign differs from the sign of a.
  - PF is 1 when bits 7..0 of the difference hold an even number of ones.
- R3: With `wide_i` low, every operation works on bits 15..0 only. Bits 31..16 of `a_i` and `b_i` have no effect on the flags.
- R4: The condition code is decoded as follows. Bits 3..1 pick the base test; bit 0 set inverts it.
  - 0: OF
  - 1: CF
  - 2: ZF
  - 3: CF or ZF
  - 4: SF
  - 5: PF
  - 6: SF xor OF
  - 7: ZF or (SF xor OF)
- R5: Operation code 1 (evaluate) tests the condition code against the held flags. It drives `taken_o` with the result and leaves the flags unchanged.
- R6: When a condition is tested, `setb_o` becomes 8'hFF if the condition is true and 8'h00 if it is false.
- R7: A compare also tests `cond_i` on its own new flags in the same cycle, and drives `taken_o` and `setb_o` from that test.
- R8: Operation codes 2, 3 and 4 act on CF only:
  - code 2 clears CF;
  - code 3 sets CF;
  - code 4 inverts CF.
  
  ZF, SF, OF and PF keep their values, and `taken_o` becomes 0.
- R9: Operation code 5 (loop) loads `count_o` with `count_i` minus one, wrapping from zero to all ones. With `wide_i` low, only bits 15..0 are decremented and bits 31..16 are copied unchanged.
- R10: The loop decision uses the new count at the active width. `lvar_i` selects the variant:
  - 0 or 3: taken when the new count is nonzero.
  - 1: taken when the new count is nonzero and ZF is 1.
  - 2: taken when the new count is nonzero and ZF is 0.
- R11: The loop operation and the reserved codes 6 and 7 leave all flags unchanged. The reserved codes set `taken_o` to 0 and change nothing else.
- R12: In a cycle with `valid_i` low, no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation select |
| wide_i | input | 1 | 1: 32-bit width, 0: 16-bit width |
| a_i | input | 32 | Compare destination operand |
| b_i | input | 32 | Compare source operand |
| cond_i | input | 4 | Condition code |
| lvar_i | input | 2 | Loop variant |
| count_i | input | 32 | Loop counter in |
| cf_o | output | 1 | Carry flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Overflow flag |
| pf_o | output | 1 | Parity flag |
| taken_o | output | 1 | Condition true / branch taken |
| setb_o | output | 8 | Set-byte value |
| count_o | output | 32 | Updated loop counter |

## Verification
A compare produces new flags and also tests a condition code against them in the same cycle. The set-byte and taken results must therefore reflect the difference just computed, not the flags held from the previous operation. The bench provokes this by following a compare with a second compare whose operands flip the chosen condition, and by sweeping all sixteen codes. The reference model recomputes the flags from the operands before it evaluates the condition, and it is compared with every output after every cycle. Back-to-back sequences are included: a carry operation or a compare is followed at once by an evaluation or a loop, so that each must read the flag state written one cycle earlier.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;

    typedef enum logic [2:0] {
        OP_CMP  = 3'd0,
        OP_EVAL = 3'd1,
        OP_CLRC = 3'd2,
        OP_SETC = 3'd3,
        OP_INVC = 3'd4,
        OP_LOOP = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        LV_PLAIN    = 2'd0,
        LV_WHILE_EQ = 2'd1,
        LV_WHILE_NE = 2'd2,
        LV_PLAIN_B  = 2'd3
    } lvar_e;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic of;
        logic pf;
    } flags_t;

    localparam flags_t FLAGS_CLEAR = '{cf: 1'b0, zf: 1'b0, sf: 1'b0, of: 1'b0, pf: 1'b0};
    localparam logic [7:0] SETB_TRUE  = 8'hFF;
    localparam logic [7:0] SETB_FALSE = 8'h00;

    // Base test chosen by cc[3:1]; cc[0] inverts it.
    function automatic logic cond_hit(flags_t f, logic [3:0] cc);
        logic base;
        unique case (cc[3:1])
            3'd0: base = f.of;
            3'd1: base = f.cf;
            3'd2: base = f.zf;
            3'd3: base = f.cf | f.zf;
            3'd4: base = f.sf;
            3'd5: base = f.pf;
            3'd6: base = f.sf ^ f.of;
            default: base = f.zf | (f.sf ^ f.of);
        endcase
        return base ^ cc[0];
    endfunction

endpackage

// File: rtl/cmpc_flaggen.sv
module cmpc_flaggen
    import cmpc_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              wide,
    output flags_t            flags
);
    localparam int PAR_W = 8;

    logic [DATA_W:0]   wdiff;
    logic [NARROW_W:0] ndiff;
    logic [DATA_W-1:0] res;
    logic              a_msb, b_msb, r_msb, borrow;

    assign wdiff = {1'b0, a} - {1'b0, b};
    assign ndiff = {1'b0, a[NARROW_W-1:0]} - {1'b0, b[NARROW_W-1:0]};

    always_comb begin
        if (wide) begin
            res    = wdiff[DATA_W-1:0];
            borrow = wdiff[DATA_W];
            a_msb  = a[DATA_W-1];
            b_msb  = b[DATA_W-1];
            r_msb  = wdiff[DATA_W-1];
        end else begin
            res    = {{(DATA_W-NARROW_W){1'b0}}, ndiff[NARROW_W-1:0]};
            borrow = ndiff[NARROW_W];
            a_msb  = a[NARROW_W-1];
            b_msb  = b[NARROW_W-1];
            r_msb  = ndiff[NARROW_W-1];
        end
    end

    assign flags.cf = borrow;
    assign flags.zf = (res == '0);
    assign flags.sf = r_msb;
    assign flags.of = (a_msb ^ b_msb) & (r_msb ^ a_msb);
    assign flags.pf = ~(^res[PAR_W-1:0]);

endmodule

// File: rtl/cmpc_condeval.sv
module cmpc_condeval
    import cmpc_pkg::*;
(
    input  flags_t     flags,
    input  logic [3:0] cc,
    output logic       hit,
    output logic [7:0] setb
);
    assign hit  = cond_hit(flags, cc);
    assign setb = hit ? SETB_TRUE : SETB_FALSE;
endmodule

// File: rtl/cmpc_loopctl.sv
module cmpc_loopctl
    import cmpc_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16
) (
    input  logic [DATA_W-1:0] count,
    input  logic              wide,
    input  lvar_e             lvar,
    input  logic              zf,
    output logic [DATA_W-1:0] next_count,
    output logic              take
);
    logic [DATA_W-1:0]   cw;
    logic [NARROW_W-1:0] cn;
    logic                nonzero;
    logic                zf_ok;

    assign cw = count - 1'b1;
    assign cn = count[NARROW_W-1:0] - 1'b1;

    assign next_count = wide ? cw : {count[DATA_W-1:NARROW_W], cn};
    assign nonzero    = wide ? (cw != '0) : (cn != '0);

    always_comb begin
        unique case (lvar)
            LV_WHILE_EQ: zf_ok = zf;
            LV_WHILE_NE: zf_ok = ~zf;
            default:     zf_ok = 1'b1;
        endcase
    end

    assign take = nonzero & zf_ok;
endmodule

// File: rtl/cmp_cond_unit.sv
module cmp_cond_unit
    import cmpc_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic [2:0]        op_i,
    input  logic              wide_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [3:0]        cond_i,
    input  logic [1:0]        lvar_i,
    input  logic [DATA_W-1:0] count_i,
    output logic              cf_o,
    output logic              zf_o,
    output logic              sf_o,
    output logic              of_o,
    output logic              pf_o,
    output logic              taken_o,
    output logic [7:0]        setb_o,
    output logic [DATA_W-1:0] count_o
);
    op_e               op;
    flags_t            flag_q, cmp_flags, eval_flags, flag_d;
    logic              cc_hit, loop_take, taken_d;
    logic [7:0]        cc_setb, setb_q, setb_d;
    logic [DATA_W-1:0] loop_cnt, count_q, count_d;
    logic              taken_q;

    assign op = op_e'(op_i);

    cmpc_flaggen #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_flaggen (
        .a     (a_i),
        .b     (b_i),
        .wide  (wide_i),
        .flags (cmp_flags)
    );

    // One evaluation path: a compare tests its fresh flags, others the held ones.
    assign eval_flags = (op == OP_CMP) ? cmp_flags : flag_q;

    cmpc_condeval u_condeval (
        .flags (eval_flags),
        .cc    (cond_i),
        .hit   (cc_hit),
        .setb  (cc_setb)
    );

    cmpc_loopctl #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_loopctl (
        .count      (count_i),
        .wide       (wide_i),
        .lvar       (lvar_e'(lvar_i)),
        .zf         (flag_q.zf),
        .next_count (loop_cnt),
        .take       (loop_take)
    );

    always_comb begin
        flag_d  = flag_q;
        taken_d = 1'b0;
        setb_d  = setb_q;
        count_d = count_q;
        unique case (op)
            OP_CMP: begin
                flag_d  = cmp_flags;
                taken_d = cc_hit;
                setb_d  = cc_setb;
            end
            OP_EVAL: begin
                taken_d = cc_hit;
                setb_d  = cc_setb;
            end
            OP_CLRC: flag_d.cf = 1'b0;
            OP_SETC: flag_d.cf = 1'b1;
            OP_INVC: flag_d.cf = ~flag_q.cf;
            OP_LOOP: begin
                count_d = loop_cnt;
                taken_d = loop_take;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q  <= FLAGS_CLEAR;
            taken_q <= 1'b0;
            setb_q  <= SETB_FALSE;
            count_q <= '0;
        end else if (valid_i) begin
            flag_q  <= flag_d;
            taken_q <= taken_d;
            setb_q  <= setb_d;
            count_q <= count_d;
        end
    end

    assign cf_o    = flag_q.cf;
    assign zf_o    = flag_q.zf;
    assign sf_o    = flag_q.sf;
    assign of_o    = flag_q.of;
    assign pf_o    = flag_q.pf;
    assign taken_o = taken_q;
    assign setb_o  = setb_q;
    assign count_o = count_q;

endmodule

// File: rtl/cmpc_chk.sv
module cmpc_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              valid_i,
    input logic [2:0]        op_i,
    input logic              wide_i,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic [3:0]        cond_i,
    input logic [DATA_W-1:0] count_i,
    input logic              cf_o,
    input logic              zf_o,
    input logic              sf_o,
    input logic              of_o,
    input logic              pf_o,
    input logic              taken_o,
    input logic [7:0]        setb_o,
    input logic [DATA_W-1:0] count_o
);
    // R2
    equal_cmp_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 3'd0 && wide_i && a_i == b_i) |=> (zf_o && !cf_o && !sf_o && !of_o));

    // R7
    cmp_zero_setb_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 3'd0 && cond_i == 4'd4) |=> ((setb_o == 8'hFF) == zf_o));

    // R6
    setb_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 3'd1) |=> (setb_o == (taken_o ? 8'hFF : 8'h00)));

    // R8
    setc_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 3'd3) |=> (cf_o && !taken_o));

    // R8
    invc_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 3'd4) |=> (cf_o != $past(cf_o)));

    // R8
    carry_op_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && (op_i == 3'd2 || op_i == 3'd3 || op_i == 3'd4))
        |=> ($stable(zf_o) && $stable(sf_o) && $stable(of_o) && $stable(pf_o)));

    // R9
    loop_wide_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 3'd5 && wide_i) |=> (count_o == $past(count_i) - 1'b1));

    // R11
    loop_flags_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == 3'd5) |=> ($stable(cf_o) && $stable(zf_o) && $stable(sf_o)));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> ($stable(cf_o) && $stable(zf_o) && $stable(taken_o)
                      && $stable(setb_o) && $stable(count_o)));
endmodule

bind cmp_cond_unit cmpc_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .valid_i (valid_i),
    .op_i    (op_i),
    .wide_i  (wide_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .cond_i  (cond_i),
    .count_i (count_i),
    .cf_o    (cf_o),
    .zf_o    (zf_o),
    .sf_o    (sf_o),
    .of_o    (of_o),
    .pf_o    (pf_o),
    .taken_o (taken_o),
    .setb_o  (setb_o),
    .count_o (count_o)
);

// File: tb/cmp_cond_unit_test.sv
`timescale 1ns/1ps
module cmp_cond_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [2:0]  op_i;
    logic        wide_i;
    logic [31:0] a_i, b_i, count_i, count_o;
    logic [3:0]  cond_i;
    logic [1:0]  lvar_i;
    logic        cf_o, zf_o, sf_o, of_o, pf_o, taken_o;
    logic [7:0]  setb_o;

    always #2.5 clk = ~clk;

    cmp_cond_unit uut (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .wide_i(wide_i),
        .a_i(a_i), .b_i(b_i), .cond_i(cond_i), .lvar_i(lvar_i), .count_i(count_i),
        .cf_o(cf_o), .zf_o(zf_o), .sf_o(sf_o), .of_o(of_o), .pf_o(pf_o),
        .taken_o(taken_o), .setb_o(setb_o), .count_o(count_o)
    );

    int vecs = 0;
    int bad  = 0;
    bit done = 0;

    // reference state
    bit        e_cf, e_zf, e_sf, e_of, e_pf, e_tk;
    bit [7:0]  e_sb;
    bit [31:0] e_cnt;

    function automatic bit cc_true(int cc, bit cf, bit zf, bit sf, bit of, bit pf);
        bit r;
        case (cc / 2)
            0: r = of;
            1: r = cf;
            2: r = zf;
            3: r = cf || zf;
            4: r = sf;
            5: r = pf;
            6: r = (sf != of);
            default: r = zf || (sf != of);
        endcase
        if (cc % 2 == 1) r = !r;
        return r;
    endfunction

    task automatic model(int op, bit wide, bit [31:0] a, bit [31:0] b, int cc, int lv, bit [31:0] cnt);
        longint mask = wide ? 64'hFFFF_FFFF : 64'hFFFF;
        int     n    = wide ? 32 : 16;
        longint av   = longint'(a) & mask;
        longint bv   = longint'(b) & mask;
        longint d    = (av - bv) & mask;
        longint nc;
        int     ones = 0;
        bit     sa, sb;
        case (op)
            0: begin
                for (int i = 0; i < 8; i++) ones += int'((d >> i) & 1);
                sa   = ((av >> (n - 1)) & 1) != 0;
                sb   = ((bv >> (n - 1)) & 1) != 0;
                e_cf = av < bv;
                e_zf = d == 0;
                e_sf = ((d >> (n - 1)) & 1) != 0;
                e_of = (sa != sb) && (e_sf != sa);
                e_pf = (ones % 2) == 0;
                e_tk = cc_true(cc, e_cf, e_zf, e_sf, e_of, e_pf);
                e_sb = e_tk ? 8'hFF : 8'h00;
            end
            1: begin
                e_tk = cc_true(cc, e_cf, e_zf, e_sf, e_of, e_pf);
                e_sb = e_tk ? 8'hFF : 8'h00;
            end
            2: begin e_cf = 0; e_tk = 0; end
            3: begin e_cf = 1; e_tk = 0; end
            4: begin e_cf = !e_cf; e_tk = 0; end
            5: begin
                nc = ((longint'(cnt) & mask) - 1) & mask;
                e_cnt = wide ? 32'(nc) : ((cnt & 32'hFFFF_0000) | 32'(nc));
                e_tk = (nc != 0) && (lv == 1 ? e_zf : (lv == 2 ? !e_zf : 1'b1));
            end
            default: e_tk = 0;
        endcase
    endtask

    task automatic chk(string tag, string nm, longint act, longint exp);
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, nm, act, exp);
        end
    endtask

    task automatic compare(string tag);
        vecs++;
        chk(tag, "cf", cf_o, e_cf);
        chk(tag, "zf", zf_o, e_zf);
        chk(tag, "sf", sf_o, e_sf);
        chk(tag, "of", of_o, e_of);
        chk(tag, "pf", pf_o, e_pf);
        chk(tag, "taken", taken_o, e_tk);
        chk(tag, "setb", setb_o, e_sb);
        chk(tag, "count", count_o, e_cnt);
    endtask

    // called at a falling edge; checks at the next falling edge
    task automatic step(string tag, int op, bit wide, bit [31:0] a, bit [31:0] b,
                        int cc, int lv, bit [31:0] cnt, bit vld = 1);
        valid_i = vld; op_i = 3'(op); wide_i = wide; a_i = a; b_i = b;
        cond_i = 4'(cc); lvar_i = 2'(lv); count_i = cnt;
        if (vld) model(op, wide, a, b, cc, lv, cnt);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    function automatic bit [31:0] pick();
        case ($urandom_range(0, 5))
            0: return 32'h8000_0000;
            1: return 32'h7FFF_FFFF;
            2: return 32'h0000_8000;
            3: return 32'h0000_7FFF;
            default: return $urandom();
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; valid_i = 0; op_i = 0; wide_i = 0; a_i = 0; b_i = 0;
        cond_i = 0; lvar_i = 0; count_i = 0;
        e_cf = 0; e_zf = 0; e_sf = 0; e_of = 0; e_pf = 0; e_tk = 0; e_sb = 0; e_cnt = 0;
        // R1: values already held are overwritten by reset
        repeat (3) @(negedge clk);
        compare("R1");
        rst = 0;

        // R2 equal operands, with R7 zero condition
        step("R2", 0, 1, 32'h1234_5678, 32'h1234_5678, 4, 0, 0);
        // R2 most negative minus one: overflow
        step("R2", 0, 1, 32'h8000_0000, 32'h0000_0001, 0, 0, 0);
        // R2 zero minus one: borrow, sign
        step("R2", 0, 1, 32'h0, 32'h1, 2, 0, 0);
        // R2 positive minus most negative: overflow the other way
        step("R2", 0, 1, 32'h7FFF_FFFF, 32'h8000_0000, 12, 0, 0);
        // R3 narrow, differing upper halves ignored
        step("R3", 0, 0, 32'hABCD_0005, 32'h1111_0005, 4, 0, 0);
        step("R3", 0, 0, 32'hFFFF_8000, 32'h0000_0001, 0, 0, 0);
        // R4/R5 all codes on held flags
        for (int c = 0; c < 16; c++) step("R5", 1, 1, 0, 0, c, 0, 0);
        // R7 compare tests its own fresh flags: back-to-back flip of ZF
        step("R7", 0, 1, 5, 5, 5, 0, 0);
        step("R7", 0, 1, 5, 6, 5, 0, 0);
        step("R6", 0, 1, 3, 9, 12, 0, 0);
        // R8 carry ops, then read carry condition back-to-back
        step("R8", 3, 1, 0, 0, 0, 0, 0);
        step("R4", 1, 1, 0, 0, 2, 0, 0);
        step("R8", 4, 1, 0, 0, 0, 0, 0);
        step("R8", 4, 1, 0, 0, 0, 0, 0);
        step("R8", 2, 1, 0, 0, 0, 0, 0);
        // R9 loop counts, wrap
        step("R9", 5, 1, 0, 0, 0, 0, 32'h1);
        step("R9", 5, 1, 0, 0, 0, 0, 32'h0);
        step("R9", 5, 0, 0, 0, 0, 0, 32'h1234_0000);
        step("R9", 5, 0, 0, 0, 0, 0, 32'hABCD_0001);
        // R10 variants with ZF = 1 then ZF = 0
        step("R10", 0, 1, 7, 7, 0, 0, 0);
        for (int v = 0; v < 4; v++) step("R10", 5, 1, 0, 0, 0, v, 32'h10);
        step("R10", 0, 1, 7, 8, 0, 0, 0);
        for (int v = 0; v < 4; v++) step("R10", 5, 1, 0, 0, 0, v, 32'h10);
        // R11 reserved codes
        step("R11", 6, 1, 32'h1, 32'h2, 3, 0, 32'h55);
        step("R11", 7, 0, 32'h9, 32'h2, 3, 0, 32'h55);
        // R12 idle cycles with changing inputs
        step("R12", 0, 1, 32'h1, 32'h1, 4, 0, 0, 0);
        step("R12", 5, 1, 0, 0, 0, 0, 32'h99, 0);
        // random mix
        for (int k = 0; k < 400; k++)
            step("R2", $urandom_range(0, 7), 1'($urandom_range(0, 1)), pick(), pick(),
                 $urandom_range(0, 15), $urandom_range(0, 3), pick(), 1'($urandom_range(0, 7) != 0));
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule